// File: doc/BRIEF.md
# Citizens-Band Channel Select Mode Controller

This block holds the operating channel of a 40-channel citizens-band transceiver and decides, every clock, which channel the synthesizer should be tuned to. It reacts to debounced up and down key levels, two emergency-channel slide switches, a public-address switch, the transmit line, a power-saving hold input, and a channel number requested by a separate preset store. All time-based behaviour (auto-repeat, beep length, relock window, blink) is counted in pulses of a 1 ms tick input, so the block runs from any fast system clock.

Its outputs are the active channel number and a registered transmit flag, which together select the divide ratio downstream. It also drives a two-glyph display code, a beep request and an unlock request that holds the transmitter off while the loop relocks. The channel in use before an emergency or public-address episode is never overwritten, so it comes back when the episode ends. Key scanning, LED multiplexing and preset storage sit outside.

Top module: `cb_chsel_ctrl`

## Requirements
- R1: After reset the active channel is 9, the display code is 8'hF9, and both beep and unlock_req are high.
- R2: In normal receive mode, a new press of up alone raises the channel by one and a new press of down alone lowers it by one; 40 steps up to 1 and 1 steps down to 40. The active channel is always within 1..40.
- R3: A key held without release gives no further step before its 500th tick; it steps on that tick and then on every 100th tick after it.
- R4: unlock_req is high while an up or down key is held and for 25 ticks after release, and for 25 ticks after any change of the active channel.
- R5: beep goes high for 50 ticks whenever a new channel is selected: a step, an accepted recall, entering, changing or leaving an emergency channel, and leaving hold.
- R6: When either emergency switch turns on in receive, the active channel becomes 9 (high-priority switch) or 19 (low-priority switch); the high-priority switch wins when both are on. When both are off again, the channel from before is restored.
- R7: An emergency switch released while tx_on is high leaves the emergency channel active until tx_on returns low.
- R8: While an emergency channel is active, up, down and recall have no effect on the channel.
- R9: While sw_pa is high, the display code is 8'hAB (glyphs P and A), unlock_req is high, and keys, recall and emergency switches do not change the channel; on release the earlier channel is active again.
- R10: While tx_on is high, keys, recall and emergency switches have no effect.
- R11: While hold_on is high, beep is low, unlock_req is high and the display code is 8'hFF, and keys are ignored; on leaving hold the previous channel is active and beep is high.
- R12: Display code: bits 7:4 tens glyph, bits 3:0 units glyph; values 0..9 are digits, 4'hA is P, 4'hB is A, 4'hF is blank, and a tens digit of 0 shows blank. An emergency channel is shown for the first 250 ticks of each 500-tick period counted from entry and is blank in the other 250.
- R13: recall_vld with recall_ch in 1..40, in normal receive mode with no key held, selects that channel; any other recall_ch value is ignored.
- R14: tx_flag follows tx_on one clock later (low in hold), and every change of tx_flag comes with unlock_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| key_up | input | 1 | Debounced up key level |
| key_dn | input | 1 | Debounced down key level |
| sw_emer_hi | input | 1 | Emergency switch for channel 9 (higher priority) |
| sw_emer_lo | input | 1 | Emergency switch for channel 19 |
| sw_pa | input | 1 | Public-address switch |
| tx_on | input | 1 | 1 = transmit, 0 = receive |
| hold_on | input | 1 | 1 = hold (power-saving) mode |
| recall_vld | input | 1 | Preset recall request strobe |
| recall_ch | input | 6 | Requested channel for a recall |
| chan | output | 6 | Active channel number |
| tx_flag | output | 1 | Registered transmit flag for divide-ratio lookup |
| disp_code | output | 8 | Two display glyphs, tens in 7:4, units in 3:0 |
| beep | output | 1 | Beep request |
| unlock_req | output | 1 | Unlock / transmit-inhibit request |

## Verification
Stepping is tried with short single presses at both band edges, which separates the wrap rule from plain increments, and with one long hold whose channel is sampled before and after the 500 ms threshold, which separates the first repeat delay from the repeat period. Emergency switches are tried one at a time, together, and released during transmit, which tells priority apart from the save and restore and from the transmit latch. Keys, recall and switches are then driven during transmit, public-address and hold, where only the unchanged channel tells lockout from action, while a behavioural model compares every output on every clock.

// File: rtl/cb_chsel_pkg.sv
package cb_chsel_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_EMER = 2'd1,
    MODE_PA   = 2'd2,
    MODE_HOLD = 2'd3
  } chsel_mode_e;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } key_dir_e;

  localparam logic [3:0] GLYPH_P     = 4'hA;
  localparam logic [3:0] GLYPH_A     = 4'hB;
  localparam logic [3:0] GLYPH_BLANK = 4'hF;

endpackage

// File: rtl/cb_chsel_dly.sv
// Millisecond down-counter: busy for DUR ticks after load.
module cb_chsel_dly #(
  parameter int DUR        = 50,
  parameter bit START_BUSY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  logic clear,
  output logic busy
);
  localparam int CW = $clog2(DUR + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = CW'(DUR);
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= START_BUSY ? CW'(DUR) : '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/cb_chsel_rpt.sv
// Key press edge and auto-repeat generator.
module cb_chsel_rpt
  import cb_chsel_pkg::*;
#(
  parameter int DELAY  = 500,
  parameter int PERIOD = 100
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  key_dir_e dir,
  output logic     step
);
  localparam int CW = $clog2(DELAY + 1);

  key_dir_e      dir_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    step  = 1'b0;
    cnt_d = cnt_q;
    if (dir != DIR_IDLE) begin
      if (dir != dir_q) begin
        step  = 1'b1;
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == CW'(DELAY - 1)) begin
          step  = 1'b1;
          cnt_d = CW'(DELAY - PERIOD);
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_IDLE;
      cnt_q <= '0;
    end else begin
      dir_q <= dir;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cb_chsel_wrap.sv
// Channel increment / decrement with wrap at both band ends.
module cb_chsel_wrap #(
  parameter int NUM_CH = 40,
  parameter int CH_W   = 6
) (
  input  logic [CH_W-1:0] cur,
  input  logic            up,
  output logic [CH_W-1:0] nxt
);
  always_comb begin
    if (up) begin
      nxt = (cur == CH_W'(NUM_CH)) ? CH_W'(1) : cur + CH_W'(1);
    end else begin
      nxt = (cur == CH_W'(1)) ? CH_W'(NUM_CH) : cur - CH_W'(1);
    end
  end
endmodule

// File: rtl/cb_chsel_disp.sv
// Two-glyph display encoder.
module cb_chsel_disp
  import cb_chsel_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  chsel_mode_e     mode,
  input  logic [CH_W-1:0] chan,
  input  logic            show,
  output logic [7:0]      code
);
  logic [3:0] tens_v, ones_v;

  assign tens_v = 4'(int'(chan) / 10);
  assign ones_v = 4'(int'(chan) % 10);

  always_comb begin
    unique case (mode)
      MODE_HOLD: code = {GLYPH_BLANK, GLYPH_BLANK};
      MODE_PA:   code = {GLYPH_P, GLYPH_A};
      default: begin
        if (!show) begin
          code = {GLYPH_BLANK, GLYPH_BLANK};
        end else begin
          code = {(tens_v == 4'd0) ? GLYPH_BLANK : tens_v, ones_v};
        end
      end
    endcase
  end
endmodule

// File: rtl/cb_chsel_ctrl.sv
module cb_chsel_ctrl
  import cb_chsel_pkg::*;
#(
  parameter int NUM_CH        = 40,
  parameter int EMER_HI_CH    = 9,
  parameter int EMER_LO_CH    = 19,
  parameter int RPT_DELAY_MS  = 500,
  parameter int RPT_PERIOD_MS = 100,
  parameter int UL_MS         = 25,
  parameter int BEEP_MS       = 50,
  parameter int BLINK_HALF_MS = 250,
  localparam int CH_W         = $clog2(NUM_CH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_1ms,
  input  logic            key_up,
  input  logic            key_dn,
  input  logic            sw_emer_hi,
  input  logic            sw_emer_lo,
  input  logic            sw_pa,
  input  logic            tx_on,
  input  logic            hold_on,
  input  logic            recall_vld,
  input  logic [CH_W-1:0] recall_ch,
  output logic [CH_W-1:0] chan,
  output logic            tx_flag,
  output logic [7:0]      disp_code,
  output logic            beep,
  output logic            unlock_req
);
  localparam int BL_W = $clog2(2 * BLINK_HALF_MS);

  chsel_mode_e     mode_q, mode_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic [CH_W-1:0] emer_q, emer_d;
  logic            tx_q, tx_d;
  logic [BL_W-1:0] blink_q, blink_d;

  key_dir_e        dir_in, eff_dir;
  logic            emer_any, key_allow, recall_ok;
  logic [CH_W-1:0] emer_sel, step_ch;
  logic            step;
  logic            beep_ld, ul_ld, quiet, blink_clr;
  logic            ul_busy, show;

  // ---------------- input decode ----------------
  always_comb begin
    if (key_up && !key_dn)      dir_in = DIR_UP;
    else if (key_dn && !key_up) dir_in = DIR_DN;
    else                        dir_in = DIR_IDLE;
  end

  assign emer_any  = sw_emer_hi | sw_emer_lo;
  assign emer_sel  = sw_emer_hi ? CH_W'(EMER_HI_CH) : CH_W'(EMER_LO_CH);
  assign key_allow = (mode_q == MODE_NORM) && !hold_on && !sw_pa && !tx_on && !emer_any;
  assign eff_dir   = key_allow ? dir_in : DIR_IDLE;
  assign recall_ok = key_allow && (eff_dir == DIR_IDLE) && recall_vld &&
                     (recall_ch >= CH_W'(1)) && (recall_ch <= CH_W'(NUM_CH));

  // ---------------- sub-blocks ----------------
  cb_chsel_rpt #(
    .DELAY  (RPT_DELAY_MS),
    .PERIOD (RPT_PERIOD_MS)
  ) u_rpt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1ms),
    .dir   (eff_dir),
    .step  (step)
  );

  cb_chsel_wrap #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_wrap (
    .cur (cur_q),
    .up  (eff_dir == DIR_UP),
    .nxt (step_ch)
  );

  cb_chsel_dly #(
    .DUR        (BEEP_MS),
    .START_BUSY (1'b1)
  ) u_beep (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1ms),
    .load  (beep_ld),
    .clear (quiet),
    .busy  (beep)
  );

  cb_chsel_dly #(
    .DUR        (UL_MS),
    .START_BUSY (1'b1)
  ) u_ul (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_1ms),
    .load  (ul_ld),
    .clear (quiet),
    .busy  (ul_busy)
  );

  // ---------------- next-state ----------------
  always_comb begin
    mode_d    = mode_q;
    cur_d     = cur_q;
    emer_d    = emer_q;
    tx_d      = tx_on;
    beep_ld   = 1'b0;
    ul_ld     = 1'b0;
    quiet     = 1'b0;
    blink_clr = 1'b0;

    if (hold_on) begin
      mode_d = MODE_HOLD;
      tx_d   = 1'b0;
      quiet  = 1'b1;
    end else if (mode_q == MODE_HOLD) begin
      mode_d  = MODE_NORM;
      beep_ld = 1'b1;
      ul_ld   = 1'b1;
    end else if (sw_pa) begin
      mode_d = MODE_PA;
    end else if (mode_q == MODE_PA) begin
      mode_d = MODE_NORM;
      ul_ld  = 1'b1;
    end else begin
      if (tx_on != tx_q) begin
        ul_ld = 1'b1;
      end
      if (mode_q == MODE_NORM) begin
        if (!tx_on && emer_any) begin
          mode_d    = MODE_EMER;
          emer_d    = emer_sel;
          beep_ld   = 1'b1;
          ul_ld     = 1'b1;
          blink_clr = 1'b1;
        end else if (step) begin
          cur_d   = step_ch;
          beep_ld = 1'b1;
        end else if (recall_ok) begin
          cur_d   = recall_ch;
          beep_ld = 1'b1;
          ul_ld   = 1'b1;
        end
        if (eff_dir != DIR_IDLE) begin
          ul_ld = 1'b1;
        end
      end else if (!tx_on) begin
        if (!emer_any) begin
          mode_d  = MODE_NORM;
          beep_ld = 1'b1;
          ul_ld   = 1'b1;
        end else if (emer_sel != emer_q) begin
          emer_d  = emer_sel;
          beep_ld = 1'b1;
          ul_ld   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    blink_d = blink_q;
    if (blink_clr) begin
      blink_d = '0;
    end else if (tick_1ms) begin
      blink_d = (blink_q == BL_W'(2 * BLINK_HALF_MS - 1)) ? '0 : blink_q + BL_W'(1);
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORM;
      cur_q   <= CH_W'(EMER_HI_CH);
      emer_q  <= CH_W'(EMER_HI_CH);
      tx_q    <= 1'b0;
      blink_q <= '0;
    end else begin
      mode_q  <= mode_d;
      cur_q   <= cur_d;
      emer_q  <= emer_d;
      tx_q    <= tx_d;
      blink_q <= blink_d;
    end
  end

  // ---------------- outputs ----------------
  assign chan       = (mode_q == MODE_EMER) ? emer_q : cur_q;
  assign tx_flag    = tx_q;
  assign unlock_req = ul_busy || (mode_q == MODE_PA) || (mode_q == MODE_HOLD);
  assign show       = (mode_q != MODE_EMER) || (blink_q < BL_W'(BLINK_HALF_MS));

  cb_chsel_disp #(
    .CH_W (CH_W)
  ) u_disp (
    .mode (mode_q),
    .chan (chan),
    .show (show),
    .code (disp_code)
  );

endmodule

// File: rtl/cb_chsel_chk.sv
module cb_chsel_chk #(
  parameter int NUM_CH = 40,
  parameter int CH_W   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_pa,
  input logic            hold_on,
  input logic            tx_on,
  input logic [CH_W-1:0] chan,
  input logic            tx_flag,
  input logic [7:0]      disp_code,
  input logic            beep,
  input logic            unlock_req
);

  // R2: channel stays inside the band
  a_r2_chan_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (chan >= CH_W'(1)) && (chan <= CH_W'(NUM_CH)));

  // R11: hold silences beep, forces unlock, blanks display
  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold_on |=> (!beep && unlock_req && (disp_code == 8'hFF)));

  // R9: public-address view and unlock
  a_r9_pa_view: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pa && !hold_on) |=> (unlock_req && (disp_code == 8'hAB)));

  // R10: transmit freezes the channel
  a_r10_tx_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && !sw_pa && !hold_on) |=> $stable(chan));

  // R5: a new channel comes with a beep
  a_r5_beep_on_new_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chan) && !$past(sw_pa) && !$past(hold_on)) |-> beep);

  // R4: a new channel comes with an unlock request
  a_r4_unlock_on_new_chan: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan) |-> unlock_req);

  // R14: a transmit/receive change comes with an unlock request
  a_r14_tx_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_flag) |-> unlock_req);

endmodule

bind cb_chsel_ctrl cb_chsel_chk #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_pa      (sw_pa),
  .hold_on    (hold_on),
  .tx_on      (tx_on),
  .chan       (chan),
  .tx_flag    (tx_flag),
  .disp_code  (disp_code),
  .beep       (beep),
  .unlock_req (unlock_req)
);

// File: tb/tb_cb_chsel_ctrl.sv
`timescale 1ns/1ps
module tb_cb_chsel_ctrl;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic       key_up = 1'b0, key_dn = 1'b0;
  logic       sw_emer_hi = 1'b0, sw_emer_lo = 1'b0, sw_pa = 1'b0;
  logic       tx_on = 1'b0, hold_on = 1'b0, recall_vld = 1'b0;
  logic [5:0] recall_ch = 6'd0;
  logic [5:0] chan;
  logic       tx_flag, beep, unlock_req;
  logic [7:0] disp_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cb_chsel_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
    .key_up(key_up), .key_dn(key_dn),
    .sw_emer_hi(sw_emer_hi), .sw_emer_lo(sw_emer_lo), .sw_pa(sw_pa),
    .tx_on(tx_on), .hold_on(hold_on),
    .recall_vld(recall_vld), .recall_ch(recall_ch),
    .chan(chan), .tx_flag(tx_flag), .disp_code(disp_code),
    .beep(beep), .unlock_req(unlock_req)
  );

  // 1 ms tick every TICK_DIV clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick_1ms <= (tdiv == 0);
  end

  // ---------------- behavioural reference model ----------------
  // mode: 0 normal, 1 emergency, 2 public address, 3 hold
  int m_mode, m_cur, m_em, m_tx, m_dir, m_rpt, m_ul, m_beep, m_blink;
  int want;
  bit emer_on;

  task automatic m_select(int c, bit relock);
    m_cur = c;
    m_beep = 50;
    if (relock) m_ul = 25;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cur = 9; m_em = 9; m_tx = 0; m_dir = 0;
      m_rpt = 0; m_ul = 25; m_beep = 50; m_blink = 0;
    end else begin
      emer_on = sw_emer_hi || sw_emer_lo;
      if (tick_1ms) begin
        if (m_ul > 0) m_ul--;
        if (m_beep > 0) m_beep--;
        m_blink = (m_blink + 1) % 500;
      end
      if (hold_on) begin
        m_mode = 3; m_tx = 0; m_ul = 0; m_beep = 0; m_dir = 0;
      end else if (m_mode == 3) begin
        m_mode = 0; m_tx = tx_on; m_beep = 50; m_ul = 25; m_dir = 0;
      end else if (sw_pa) begin
        m_mode = 2; m_tx = tx_on; m_dir = 0;
      end else if (m_mode == 2) begin
        m_mode = 0; m_tx = tx_on; m_ul = 25; m_dir = 0;
      end else begin
        if (int'(tx_on) != m_tx) m_ul = 25;
        m_tx = tx_on;
        if (m_mode == 0) begin
          if (!tx_on && emer_on) begin
            m_mode = 1; m_em = sw_emer_hi ? 9 : 19;
            m_beep = 50; m_ul = 25; m_blink = 0; m_dir = 0;
          end else if (tx_on) begin
            m_dir = 0;
          end else begin
            want = (key_up && !key_dn) ? 1 : ((key_dn && !key_up) ? 2 : 0);
            if (want != 0) begin
              m_ul = 25;
              if (want != m_dir) begin
                m_select(want == 1 ? (m_cur % 40) + 1 : ((m_cur + 38) % 40) + 1, 0);
                m_rpt = 0;
              end else if (tick_1ms) begin
                if (m_rpt == 499) begin
                  m_select(want == 1 ? (m_cur % 40) + 1 : ((m_cur + 38) % 40) + 1, 0);
                  m_rpt = 400;
                end else begin
                  m_rpt++;
                end
              end
            end else if (recall_vld && recall_ch >= 1 && recall_ch <= 40) begin
              m_select(int'(recall_ch), 1);
            end
            m_dir = want;
          end
        end else begin
          m_dir = 0;
          if (!tx_on) begin
            if (!emer_on) begin
              m_mode = 0; m_beep = 50; m_ul = 25;
            end else if ((sw_emer_hi ? 9 : 19) != m_em) begin
              m_em = sw_emer_hi ? 9 : 19; m_beep = 50; m_ul = 25;
            end
          end
        end
      end
    end
  end

  function automatic int exp_disp();
    int c;
    c = (m_mode == 1) ? m_em : m_cur;
    if (m_mode == 3) return 8'hFF;
    if (m_mode == 2) return 8'hAB;
    if (m_mode == 1 && m_blink >= 250) return 8'hFF;
    return (((c / 10) == 0 ? 15 : (c / 10)) << 4) | (c % 10);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 chan vs model", int'(chan), (m_mode == 1) ? m_em : m_cur);
      chk("R14 tx_flag vs model", int'(tx_flag), m_tx);
      chk("R5 beep vs model", int'(beep), int'(m_beep > 0));
      chk("R4 unlock vs model", int'(unlock_req), int'(m_ul > 0 || m_mode >= 2));
      chk("R12 display vs model", int'(disp_code), exp_disp());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ms(int n);
    cyc(n * TICK_DIV);
  endtask

  task automatic press(bit up, int ms);
    if (up) key_up = 1'b1; else key_dn = 1'b1;
    wait_ms(ms);
    key_up = 1'b0; key_dn = 1'b0;
    cyc(2);
  endtask

  task automatic recall(int c);
    recall_ch = 6'(c); recall_vld = 1'b1;
    cyc(1);
    recall_vld = 1'b0;
    cyc(2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 reset chan", int'(chan), 9);
    chk("R1 reset display", int'(disp_code), 8'hF9);
    chk("R1 reset beep", int'(beep), 1);
    chk("R1 reset unlock", int'(unlock_req), 1);

    // R2 single step, R4 unlock window after release
    wait_ms(60);
    press(1, 10);
    chk("R2 up step", int'(chan), 10);
    chk("R5 beep after step", int'(beep), 1);
    wait_ms(20);
    chk("R4 unlock inside window", int'(unlock_req), 1);
    wait_ms(10);
    chk("R4 unlock after window", int'(unlock_req), 0);

    // R13 recall, R2 wrap both ways
    recall(40);
    chk("R13 recall 40", int'(chan), 40);
    press(1, 5);
    chk("R2 wrap 40 to 1", int'(chan), 1);
    press(0, 5);
    chk("R2 wrap 1 to 40", int'(chan), 40);
    recall(0);
    chk("R13 recall 0 ignored", int'(chan), 40);
    recall(41);
    chk("R13 recall 41 ignored", int'(chan), 40);

    // R3 auto-repeat
    recall(1);
    key_up = 1'b1;
    wait_ms(450);
    chk("R3 no repeat before 500 ms", int'(chan), 2);
    wait_ms(270);
    key_up = 1'b0;
    cyc(2);
    chk("R3 repeats at 500/600/700 ms", int'(chan), 5);

    // R6 emergency priority and restore, R8 lockout
    wait_ms(60);
    sw_emer_lo = 1'b1; cyc(2);
    chk("R6 low switch gives 19", int'(chan), 19);
    sw_emer_hi = 1'b1; cyc(2);
    chk("R6 high switch wins", int'(chan), 9);
    press(1, 5);
    chk("R8 up ignored in emergency", int'(chan), 9);
    recall(3);
    chk("R8 recall ignored in emergency", int'(chan), 9);
    sw_emer_hi = 1'b0; sw_emer_lo = 1'b0; cyc(2);
    chk("R6 previous channel restored", int'(chan), 5);

    // R12 blink
    wait_ms(60);
    sw_emer_hi = 1'b1;
    wait_ms(100);
    chk("R12 blink shown", int'(disp_code), 8'hF9);
    wait_ms(250);
    chk("R12 blink blank", int'(disp_code), 8'hFF);
    wait_ms(250);
    chk("R12 blink shown again", int'(disp_code), 8'hF9);

    // R7 emergency held through transmit, R14 flag
    tx_on = 1'b1; cyc(2);
    chk("R14 tx_flag follows", int'(tx_flag), 1);
    chk("R14 unlock on tx change", int'(unlock_req), 1);
    sw_emer_hi = 1'b0;
    wait_ms(5);
    chk("R7 emergency kept in transmit", int'(chan), 9);
    tx_on = 1'b0; cyc(2);
    chk("R7 restore after receive", int'(chan), 5);

    // R10 transmit lockout
    wait_ms(60);
    tx_on = 1'b1;
    wait_ms(30);
    press(1, 10);
    recall(20);
    sw_emer_lo = 1'b1; wait_ms(5); sw_emer_lo = 1'b0; cyc(2);
    chk("R10 channel frozen in transmit", int'(chan), 5);
    tx_on = 1'b0; cyc(2);
    chk("R14 tx_flag back to receive", int'(tx_flag), 0);

    // R9 public address
    wait_ms(60);
    sw_pa = 1'b1; cyc(2);
    chk("R9 PA display", int'(disp_code), 8'hAB);
    chk("R9 PA unlock", int'(unlock_req), 1);
    press(1, 10);
    sw_emer_hi = 1'b1; wait_ms(5); sw_emer_hi = 1'b0; cyc(2);
    sw_pa = 1'b0; cyc(2);
    chk("R9 channel after PA", int'(chan), 5);
    chk("R9 display after PA", int'(disp_code), 8'hF5);

    // R11 hold
    wait_ms(60);
    hold_on = 1'b1; cyc(2);
    chk("R11 hold beep low", int'(beep), 0);
    chk("R11 hold unlock", int'(unlock_req), 1);
    chk("R11 hold display blank", int'(disp_code), 8'hFF);
    press(1, 10);
    hold_on = 1'b0; cyc(2);
    chk("R11 channel after hold", int'(chan), 5);
    chk("R11 beep after hold", int'(beep), 1);

    wait_ms(40);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

endmodule